// File: doc/BRIEF.md
# Serial Disk Sector Assembler

This block sits behind the read channel of a disk drive and turns the recovered serial bit stream back into a sector. It searches the incoming bits for a fixed 16-bit synchronisation word. Once the word is found, it captures a 32-bit header made of a cylinder number, a sector number and a size code. It then shifts the payload bits into a local byte buffer. Last comes a 16-bit check code, which the block compares with a CRC it computes over the header and the payload.

When the check code has arrived, the block raises an interrupt that stays up until software clears it. A status flag tells whether the check matched. The buffered payload then leaves through a byte-wide ready/valid port in the order it arrived. While bytes are still waiting to be read, the block does not search for a new sector, so the buffer cannot be overwritten before it is drained.

Top module: `sector_assembler`

## Requirements
- R1: After reset, irq, crc_bad and rd_valid are 0, and the three header outputs are 0.
- R2: A sector starts only when the last 16 bits taken from the stream (bit_valid high), with the most recent bit as LSB, equal 0xA1F5. Bits before that point, including near-misses of the pattern, start nothing.
- R3: After the sync word come 32 header bits, MSB first: cylinder[15:0], then sector number[7:0], then size code[7:0]. They appear on hdr_cyl, hdr_sec and hdr_size and hold until the next accepted header.
- R4: There are 512 payload bytes, each formed from 8 bits MSB first. They are presented on rd_data in arrival order, and a byte is consumed on a clock edge where rd_valid and rd_ready are both high. While rd_valid is high and rd_ready is low, rd_data and rd_valid hold.
- R5: The check value is a CRC-16 with polynomial 0x1021 and initial value 0xFFFF, computed bit-serially and MSB first over the 32 header bits and the payload bits. The 16 received check bits are MSB first. If they match, crc_bad is 0.
- R6: If the received check value differs from the computed one, crc_bad is 1 and irq is still raised. crc_bad changes only at the end of a check, while irq is high.
- R7: irq rises on the clock edge that takes the last check bit and stays high until an irq_clear pulse. irq is 0 on the cycle after irq_clear, except when a new check completes on that same edge; in that case the set wins.
- R8: While buffered bytes are unread, incoming bits, including a complete new sector with a valid sync word, change neither the header outputs, the buffer contents nor irq.
- R9: bit_in is ignored on every cycle where bit_valid is low.
- R10: rd_valid stays low until the check completes. After the last of the 512 bytes is accepted, rd_valid falls and the sync search resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit from the read channel |
| bit_valid | input | 1 | bit_in carries a new bit this cycle |
| irq_clear | input | 1 | Pulse that drops the interrupt |
| rd_ready | input | 1 | Consumer accepts the presented byte |
| rd_data | output | 8 | Buffered payload byte |
| rd_valid | output | 1 | rd_data holds an unread byte |
| irq | output | 1 | Sector-complete interrupt, sticky |
| crc_bad | output | 1 | Check value of the last sector mismatched |
| hdr_cyl | output | 16 | Captured cylinder number |
| hdr_sec | output | 8 | Captured sector number |
| hdr_size | output | 8 | Captured size code |

## Verification
The hardest situation to reach from the ports is a full sector that arrives, with a valid sync word, while the previous sector's bytes are still unread. This is the case where the buffer could be overwritten without anyone noticing. The stimulus delivers a sector, clears the interrupt, and holds rd_ready low while it streams a second sector with a different header and payload. It then checks that the header outputs and irq did not move, and that draining with back-pressure returns exactly the first sector's bytes. Idle cycles carrying junk on bit_in are spread through every sector, and a sector with a corrupted check value follows, to show that the status flag and the interrupt behave independently.

// File: rtl/sector_pkg.sv
package sector_pkg;

    localparam int          CRC_W        = 16;
    localparam logic [15:0] CRC_POLY     = 16'h1021;
    localparam logic [15:0] CRC_SEED     = 16'hFFFF;
    localparam logic [15:0] SYNC_DEFAULT = 16'hA1F5;
    localparam int          HDR_BITS     = 32;

    typedef enum logic [2:0] {
        PH_HUNT,
        PH_HEADER,
        PH_PAYLOAD,
        PH_CHECK,
        PH_DRAIN
    } phase_t;

    typedef struct packed {
        logic [15:0] cyl;
        logic [7:0]  sec;
        logic [7:0]  size;
    } sec_hdr_t;

    // One serial step of an MSB-first CRC
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                  input logic             b,
                                                  input logic [CRC_W-1:0] poly);
        logic fb;
        fb = cur[CRC_W-1] ^ b;
        return {cur[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    endfunction

endpackage

// File: rtl/sas_sync_detect.sv
module sas_sync_detect #(
    parameter int          W       = 16,
    parameter logic [15:0] PATTERN = 16'hA1F5
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    input  logic flush,
    input  logic bit_in,
    output logic hit
);
    logic [W-2:0] win;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            win <= '0;
        end else if (shift_en) begin
            win <= {win[W-3:0], bit_in};
        end
    end

    assign hit = shift_en && ({win, bit_in} == PATTERN[W-1:0]);
endmodule

// File: rtl/sas_crc_serial.sv
module sas_crc_serial
    import sector_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = CRC_POLY,
    parameter logic [CRC_W-1:0] SEED = CRC_SEED
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             step,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || init) begin
            crc <= SEED;
        end else if (step) begin
            crc <= crc_step(crc, bit_in, POLY);
        end
    end
endmodule

// File: rtl/sas_byte_buffer.sv
module sas_byte_buffer #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sector_assembler.sv
module sector_assembler
    import sector_pkg::*;
#(
    parameter logic [15:0] SYNC_WORD     = SYNC_DEFAULT,
    parameter int          PAYLOAD_BYTES = 512   // power of two
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_in,
    input  logic        bit_valid,
    input  logic        irq_clear,
    input  logic        rd_ready,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    output logic        irq,
    output logic        crc_bad,
    output logic [15:0] hdr_cyl,
    output logic [7:0]  hdr_sec,
    output logic [7:0]  hdr_size
);
    localparam int PAYLOAD_BITS = PAYLOAD_BYTES * 8;
    localparam int AW           = $clog2(PAYLOAD_BYTES);
    localparam int CNT_W        = (PAYLOAD_BITS > HDR_BITS) ? $clog2(PAYLOAD_BITS)
                                                            : $clog2(HDR_BITS);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] PAY_LAST = CNT_W'(PAYLOAD_BITS - 1);
    localparam logic [CNT_W-1:0] CHK_LAST = CNT_W'(CRC_W - 1);
    localparam logic [AW-1:0]    RD_LAST  = AW'(PAYLOAD_BYTES - 1);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic [HDR_BITS-2:0] hdr_sr;
    sec_hdr_t         hdr_q;
    logic [6:0]       byte_sr;
    logic [CRC_W-2:0] chk_sr;
    logic [AW-1:0]    rd_ptr;
    logic [CRC_W-1:0] crc_now;
    logic             sync_hit;
    logic             wr_en;
    logic [7:0]       wr_byte;

    sas_sync_detect #(.W(16), .PATTERN(SYNC_WORD)) i_sync (
        .clk      (clk),
        .rst      (rst),
        .shift_en (bit_valid && (phase == PH_HUNT)),
        .flush    (phase == PH_DRAIN),
        .bit_in   (bit_in),
        .hit      (sync_hit)
    );

    sas_crc_serial #(.POLY(CRC_POLY), .SEED(CRC_SEED)) i_crc (
        .clk    (clk),
        .rst    (rst),
        .init   (sync_hit),
        .step   (bit_valid && (phase == PH_HEADER || phase == PH_PAYLOAD)),
        .bit_in (bit_in),
        .crc    (crc_now)
    );

    assign wr_en   = bit_valid && (phase == PH_PAYLOAD) && (cnt[2:0] == 3'd7);
    assign wr_byte = {byte_sr, bit_in};

    sas_byte_buffer #(.DEPTH(PAYLOAD_BYTES), .AW(AW)) i_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (cnt[3 +: AW]),
        .wr_data (wr_byte),
        .rd_addr (rd_ptr),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_HUNT;
            cnt     <= '0;
            hdr_sr  <= '0;
            hdr_q   <= '0;
            byte_sr <= '0;
            chk_sr  <= '0;
            rd_ptr  <= '0;
            irq     <= 1'b0;
            crc_bad <= 1'b0;
        end else begin
            if (irq_clear) irq <= 1'b0;
            unique case (phase)
                PH_HUNT: begin
                    if (sync_hit) begin
                        phase <= PH_HEADER;
                        cnt   <= '0;
                    end
                end
                PH_HEADER: begin
                    if (bit_valid) begin
                        hdr_sr <= {hdr_sr[HDR_BITS-3:0], bit_in};
                        if (cnt == HDR_LAST) begin
                            hdr_q <= sec_hdr_t'({hdr_sr, bit_in});
                            phase <= PH_PAYLOAD;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_PAYLOAD: begin
                    if (bit_valid) begin
                        byte_sr <= wr_byte[6:0];
                        if (cnt == PAY_LAST) begin
                            phase <= PH_CHECK;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_CHECK: begin
                    if (bit_valid) begin
                        chk_sr <= {chk_sr[CRC_W-3:0], bit_in};
                        if (cnt == CHK_LAST) begin
                            crc_bad <= ({chk_sr, bit_in} != crc_now);
                            irq     <= 1'b1;
                            rd_ptr  <= '0;
                            phase   <= PH_DRAIN;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_DRAIN: begin
                    if (rd_ready) begin
                        if (rd_ptr == RD_LAST) begin
                            phase <= PH_HUNT;
                        end else begin
                            rd_ptr <= rd_ptr + 1'b1;
                        end
                    end
                end
                default: phase <= PH_HUNT;
            endcase
        end
    end

    assign rd_valid = (phase == PH_DRAIN);
    assign hdr_cyl  = hdr_q.cyl;
    assign hdr_sec  = hdr_q.sec;
    assign hdr_size = hdr_q.size;
endmodule

// File: rtl/sector_assembler_chk.sv
module sector_assembler_chk (
    input logic        clk,
    input logic        rst,
    input logic        irq_clear,
    input logic        rd_ready,
    input logic [7:0]  rd_data,
    input logic        rd_valid,
    input logic        irq,
    input logic        crc_bad,
    input logic [15:0] hdr_cyl,
    input logic [7:0]  hdr_sec,
    input logic [7:0]  hdr_size
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!irq && !rd_valid && !crc_bad));

    // R4
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clear) |=> irq);

    // R10
    drain_after_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> irq);

    // R8
    header_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> ($stable(hdr_cyl) && $stable(hdr_sec) && $stable(hdr_size)));

    // R6
    status_only_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(crc_bad) |-> irq);
endmodule

bind sector_assembler sector_assembler_chk i_sector_assembler_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_clear (irq_clear),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .irq       (irq),
    .crc_bad   (crc_bad),
    .hdr_cyl   (hdr_cyl),
    .hdr_sec   (hdr_sec),
    .hdr_size  (hdr_size)
);

// File: tb/test_sector_assembler.sv
`timescale 1ns/100ps
module test_sector_assembler;
    localparam int NBYTES = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_in = 1'b0;
    logic        bit_valid = 1'b0;
    logic        irq_clear = 1'b0;
    logic        rd_ready = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        irq;
    logic        crc_bad;
    logic [15:0] hdr_cyl;
    logic [7:0]  hdr_sec;
    logic [7:0]  hdr_size;

    int checks = 0;
    int fails  = 0;
    int gap_ctr = 0;
    logic [15:0] crc_acc;
    logic [7:0]  exp_q[$];

    always #2.5 clk = ~clk;

    sector_assembler i_sector_assembler (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid),
        .irq_clear(irq_clear), .rd_ready(rd_ready), .rd_data(rd_data),
        .rd_valid(rd_valid), .irq(irq), .crc_bad(crc_bad),
        .hdr_cyl(hdr_cyl), .hdr_sec(hdr_sec), .hdr_size(hdr_size)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic b);
        logic [15:0] n;
        n = {c[14:0], 1'b0};
        if (c[15] ^ b) n = n ^ 16'h1021;
        return n;
    endfunction

    // R9: every fifth bit is preceded by an idle cycle carrying junk
    task automatic put_bit(input logic b);
        gap_ctr++;
        if (gap_ctr % 5 == 0) begin
            @(negedge clk);
            bit_valid = 1'b0;
            bit_in    = ~b;
        end
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in    = b;
    endtask

    task automatic put_word(input logic [31:0] w, input int n, input bit acc);
        for (int i = n - 1; i >= 0; i--) begin
            if (acc) crc_acc = ref_crc(crc_acc, w[i]);
            put_bit(w[i]);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        bit_valid = 1'b0;
        bit_in    = 1'b0;
    endtask

    function automatic logic [7:0] pay_byte(input int i, input int seed);
        return 8'((i * (seed | 1)) ^ (i >> 3) ^ seed);
    endfunction

    task automatic send_sector(input logic [15:0] cyl, input logic [7:0] sec,
                               input logic [7:0] sz, input int seed,
                               input bit corrupt, input bit push);
        logic [15:0] chkv;
        // R2: near-miss of the sync pattern, then junk, then the real word
        put_word(32'hA1F4, 16, 1'b0);
        put_word(32'h3C, 8, 1'b0);
        put_word(32'hA1F5, 16, 1'b0);
        crc_acc = 16'hFFFF;
        put_word({cyl, sec, sz}, 32, 1'b1);
        for (int i = 0; i < NBYTES; i++) begin
            put_word(32'(pay_byte(i, seed)), 8, 1'b1);
            if (push) exp_q.push_back(pay_byte(i, seed));
        end
        chkv = corrupt ? (crc_acc ^ 16'h0001) : crc_acc;
        for (int i = 15; i >= 1; i--) put_bit(chkv[i]);
        @(negedge clk);
        #1;
        if (push) begin
            // R10: no data offered before the check completes
            chk(rd_valid == 1'b0, "R10", 32'(rd_valid), 32'h0);
        end
        bit_valid = 1'b1;
        bit_in    = chkv[0];
        idle();
        #1;
    endtask

    // Monitor: pops the scoreboard on every accepted byte
    task automatic drain(input bit stall);
        int k = 0;
        logic [7:0] held = '0;
        bit was_stalled = 1'b0;
        while (exp_q.size() > 0 && k < 5000) begin
            @(negedge clk);
            rd_ready = stall ? (k % 3 != 2) : 1'b1;
            #1;
            if (was_stalled) begin
                chk(rd_valid && rd_data == held, "R4", {23'b0, rd_valid, rd_data},
                    {24'h1, held});
            end
            was_stalled = 1'b0;
            if (rd_valid && rd_ready) begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R4", 32'(rd_data), 32'(e));
            end else if (rd_valid) begin
                held = rd_data;
                was_stalled = 1'b1;
            end
            k++;
        end
        @(negedge clk);
        rd_ready = 1'b0;
        #1;
        chk(rd_valid == 1'b0, "R10", 32'(rd_valid), 32'h0);
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
        #1;
        chk(irq == 1'b0, "R7", 32'(irq), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(irq == 1'b0 && crc_bad == 1'b0 && rd_valid == 1'b0, "R1",
            {irq, crc_bad, rd_valid}, 32'h0);
        chk({hdr_cyl, hdr_sec, hdr_size} == 32'h0, "R1",
            {hdr_cyl, hdr_sec, hdr_size}, 32'h0);

        // Sector A: good check value
        send_sector(16'h1234, 8'h07, 8'h02, 5, 1'b0, 1'b1);
        chk(irq == 1'b1, "R7", 32'(irq), 32'h1);
        chk(crc_bad == 1'b0, "R5", 32'(crc_bad), 32'h0);
        chk({hdr_cyl, hdr_sec, hdr_size} == 32'h1234_0702, "R3",
            {hdr_cyl, hdr_sec, hdr_size}, 32'h1234_0702);
        chk(rd_valid == 1'b1, "R10", 32'(rd_valid), 32'h1);
        repeat (4) @(negedge clk);
        #1;
        chk(irq == 1'b1, "R7", 32'(irq), 32'h1);
        clear_irq();

        // Sector B arrives while A is unread: must be ignored
        send_sector(16'hBEEF, 8'h2A, 8'h03, 77, 1'b0, 1'b0);
        chk(irq == 1'b0, "R8", 32'(irq), 32'h0);
        chk({hdr_cyl, hdr_sec, hdr_size} == 32'h1234_0702, "R8",
            {hdr_cyl, hdr_sec, hdr_size}, 32'h1234_0702);
        drain(1'b1);

        // Sector C: corrupted check value
        send_sector(16'h0F0F, 8'hFF, 8'h01, 200, 1'b1, 1'b1);
        chk(irq == 1'b1, "R6", 32'(irq), 32'h1);
        chk(crc_bad == 1'b1, "R6", 32'(crc_bad), 32'h1);
        drain(1'b0);
        clear_irq();

        // Sector D: good again after a bad one
        send_sector(16'h8001, 8'h00, 8'hC4, 3, 1'b0, 1'b1);
        chk(crc_bad == 1'b0, "R5", 32'(crc_bad), 32'h0);
        chk({hdr_cyl, hdr_sec, hdr_size} == 32'h8001_00C4, "R3",
            {hdr_cyl, hdr_sec, hdr_size}, 32'h8001_00C4);
        drain(1'b1);
        clear_irq();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule